// File: doc/BRIEF.md
# Constant-Rate Medium Clock Divider with Gear Shift

This block turns a high-speed oscillator, which may run at any of four settings (32, 24, 16 or 4 MHz), into a secondary clock that always runs at 4 MHz. Each setting has an integer divide ratio, and the block swaps ratios whenever the oscillator setting changes. Software chooses a setting with a two-bit code. When low-power gear shifting is enabled and the system enters its stop mode, the control path moves the oscillator to its low setting and bypasses the divider. When the system leaves stop mode, the oscillator returns to the user's setting.

Every change to the setting is committed only at the boundary of an output period. That boundary is also a boundary of an oscillator cycle. So the new oscillator rate and the new ratio both take effect from the first edge of the next output period. Because of this, the secondary clock never shows a runt, a glitch or a stretched period. A change that arrives partway through a period waits in a pending register. A one-cycle done flag marks the moment the change takes effect.

For simulation, time is counted in cycles of one reference clock. Each oscillator setting is represented by a per-cycle enable, `src_tick`, that fires once every `OUT_PERIOD / ratio` reference cycles. With the default `OUT_PERIOD` of 24, one reference cycle stands for 1/96 µs.

Top module: `gs_mfclk_div`

## Requirements
- R1: Consecutive `mf_tick` pulses are always exactly `OUT_PERIOD` (24) reference cycles apart, in every setting and across every change of setting.
- R2: While reset is low, and on the first cycle after it is released, `act_code` is 00 (the 32 MHz base setting, ratio 8) and `shift_done` is 0. While reset is low, `mf_clk` is also 0. On the first cycle after release, `mf_tick` and `mf_clk` are both 1.
- R3: Codes map to settings and ratios as 00→32 MHz /8, 01→24 MHz /6, 10→16 MHz /4 and 11→4 MHz /1. During each output period, `src_tick` pulses exactly ratio times, with the ratio taken from `act_code` at the period start.
- R4: `mf_clk` is high for exactly half of each output period (12 of 24 cycles), and it rises in the same cycle as `mf_tick`.
- R5: `act_code` changes only in the cycle just before an `mf_tick` pulse. A request that arrives partway through a period has no visible effect until that boundary.
- R6: `shift_done` is high for exactly one cycle in the cycle where `act_code` takes a new value, and it is never high at any other time.
- R7: When `gs_en` and `stop_mode` are both 1, the low setting (code 11) becomes the target. When either one is 0, the target is `freq_sel`. In particular, `stop_mode` alone, with `gs_en` at 0, changes neither `act_code` nor `shift_done`.
- R8: If a user code change and a gear-shift request arrive in the same cycle, the gear shift wins, and the user code is never committed on the way to the low setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each setting is an enable on it |
| rst_n | input | 1 | Active-low reset (brownout class) |
| freq_sel | input | 2 | User-selected oscillator setting code |
| stop_mode | input | 1 | System is in stop mode |
| gs_en | input | 1 | Gear shift allowed in stop mode |
| mf_clk | output | 1 | Constant-rate secondary clock, 50% duty |
| mf_tick | output | 1 | One-cycle pulse at each secondary rising edge |
| src_tick | output | 1 | Oscillator edge enable at the active setting |
| act_code | output | 2 | Setting code currently in effect |
| shift_done | output | 1 | One-cycle pulse when a new setting takes effect |

## Verification
On every cycle, the assertions check the fixed output period, the rise of `mf_clk` together with `mf_tick`, the rule that `act_code` holds outside period boundaries, the pairing of `shift_done` with code changes, and the low-setting target while gear shifting in stop mode. The count of oscillator edges per period, the duty count, the committed code after each stimulus, the hold of a mid-period request and the same-cycle priority case can only be shown by the bench's scenarios. The bench measures these at the ports against its own ratio table.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [1:0] {
    GS_F32 = 2'd0,
    GS_F24 = 2'd1,
    GS_F16 = 2'd2,
    GS_F4  = 2'd3
  } gs_code_e;

  localparam gs_code_e    GS_BASE      = GS_F32;
  localparam gs_code_e    GS_LOW       = GS_F4;
  localparam int unsigned GS_MAX_RATIO = 8;

  // oscillator cycles per output period
  function automatic int unsigned gs_ratio(input gs_code_e c);
    unique case (c)
      GS_F32:  return 8;
      GS_F24:  return 6;
      GS_F16:  return 4;
      GS_F4:   return 1;
      default: return 8;
    endcase
  endfunction

  // reference cycles per oscillator cycle
  function automatic int unsigned gs_step(input int unsigned period, input gs_code_e c);
    return period / gs_ratio(c);
  endfunction

  // position inside the output period, in reference cycles
  function automatic int unsigned gs_phase(input int unsigned period, input gs_code_e c,
                                           input int unsigned div_i, input int unsigned osc_i);
    return div_i * gs_step(period, c) + osc_i;
  endfunction

endpackage

// File: rtl/gs_target_sel.sv
module gs_target_sel
  import gs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] freq_sel,
  input  logic       stop_mode,
  input  logic       gs_en,
  output logic       gear_req,
  output gs_code_e   pend_code
);

  gs_code_e target;

  // a gear shift overrides any user code in the same cycle
  assign gear_req = gs_en & stop_mode;
  assign target   = gear_req ? GS_LOW : gs_code_e'(freq_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_code <= GS_BASE;
    else        pend_code <= target;
  end

endmodule

// File: rtl/gs_src_model.sv
module gs_src_model
  import gs_pkg::*;
#(
  parameter  int unsigned OUT_PERIOD = 24,
  localparam int unsigned CW         = $clog2(OUT_PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gs_code_e      act_code,
  input  logic          restart,
  output logic [CW-1:0] osc_cnt,
  output logic          osc_wrap
);

  logic [CW-1:0] step_m1;

  assign step_m1  = CW'(gs_step(OUT_PERIOD, act_code) - 1);
  assign osc_wrap = (osc_cnt == step_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   osc_cnt <= '0;
    else if (restart || osc_wrap) osc_cnt <= '0;
    else                          osc_cnt <= osc_cnt + 1'b1;
  end

endmodule

// File: rtl/gs_div_core.sv
module gs_div_core
  import gs_pkg::*;
#(
  localparam int unsigned DW = $clog2(GS_MAX_RATIO)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_wrap,
  input  gs_code_e      pend_code,
  output logic [DW-1:0] div_cnt,
  output gs_code_e      act_code,
  output logic          terminal,
  output logic          shift_done
);

  logic [DW-1:0] last_cnt;

  assign last_cnt = DW'(gs_ratio(act_code) - 1);
  assign terminal = osc_wrap && (div_cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt    <= '0;
      act_code   <= GS_BASE;
      shift_done <= 1'b0;
    end else begin
      shift_done <= terminal && (pend_code != act_code);
      if (terminal) begin
        div_cnt  <= '0;
        act_code <= pend_code;
      end else if (osc_wrap) begin
        div_cnt  <= div_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/gs_out_shaper.sv
module gs_out_shaper
  import gs_pkg::*;
#(
  parameter  int unsigned OUT_PERIOD = 24,
  localparam int unsigned CW         = $clog2(OUT_PERIOD),
  localparam int unsigned DW         = $clog2(GS_MAX_RATIO),
  localparam int unsigned HALF       = OUT_PERIOD / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gs_code_e      act_code,
  input  logic [CW-1:0] osc_cnt,
  input  logic [DW-1:0] div_cnt,
  output logic          mf_clk,
  output logic          mf_tick,
  output logic          src_tick
);

  logic [CW-1:0] pos;

  assign pos = CW'(gs_phase(OUT_PERIOD, act_code, 32'(div_cnt), 32'(osc_cnt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_clk   <= 1'b0;
      mf_tick  <= 1'b0;
      src_tick <= 1'b0;
    end else begin
      mf_clk   <= (pos < CW'(HALF));
      mf_tick  <= (pos == '0);
      src_tick <= (osc_cnt == '0);
    end
  end

endmodule

// File: rtl/gs_mfclk_div.sv
module gs_mfclk_div
  import gs_pkg::*;
#(
  parameter  int unsigned OUT_PERIOD = 24,
  localparam int unsigned CW         = $clog2(OUT_PERIOD),
  localparam int unsigned DW         = $clog2(GS_MAX_RATIO)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] freq_sel,
  input  logic       stop_mode,
  input  logic       gs_en,
  output logic       mf_clk,
  output logic       mf_tick,
  output logic       src_tick,
  output logic [1:0] act_code,
  output logic       shift_done
);

  // named internal events, used by the bound checker
  logic          gear_req;
  gs_code_e      pend_code;
  gs_code_e      act_q;
  logic          terminal;
  logic          osc_wrap;
  logic [CW-1:0] osc_cnt;
  logic [DW-1:0] div_cnt;

  gs_target_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_sel  (freq_sel),
    .stop_mode (stop_mode),
    .gs_en     (gs_en),
    .gear_req  (gear_req),
    .pend_code (pend_code)
  );

  gs_src_model #(.OUT_PERIOD(OUT_PERIOD)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_code (act_q),
    .restart  (terminal),
    .osc_cnt  (osc_cnt),
    .osc_wrap (osc_wrap)
  );

  gs_div_core u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_wrap   (osc_wrap),
    .pend_code  (pend_code),
    .div_cnt    (div_cnt),
    .act_code   (act_q),
    .terminal   (terminal),
    .shift_done (shift_done)
  );

  gs_out_shaper #(.OUT_PERIOD(OUT_PERIOD)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_code (act_q),
    .osc_cnt  (osc_cnt),
    .div_cnt  (div_cnt),
    .mf_clk   (mf_clk),
    .mf_tick  (mf_tick),
    .src_tick (src_tick)
  );

  assign act_code = act_q;

endmodule

// File: rtl/gs_mfclk_chk.sv
module gs_mfclk_chk #(
  parameter int unsigned OUT_PERIOD = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mf_clk,
  input logic       mf_tick,
  input logic [1:0] act_code,
  input logic       shift_done,
  input logic       gear_req,
  input logic [1:0] pend_code,
  input logic       terminal
);

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (mf_tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap  <= gap + 1'b1;
    end
  end

  a_r1_const_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_tick && seen) |-> (gap == 16'(OUT_PERIOD - 1)));

  a_r2_base_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (act_code == 2'd0 && !shift_done));

  a_r4_clk_rises_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    mf_tick |-> (mf_clk && !$past(mf_clk)));

  a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !terminal |=> $stable(act_code));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |=> !shift_done);

  a_r6_done_with_change: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code != $past(act_code)) |-> shift_done);

  a_r7_gear_low: assert property (@(posedge clk) disable iff (!rst_n)
    gear_req |=> (pend_code == 2'd3));

endmodule

bind gs_mfclk_div gs_mfclk_chk #(.OUT_PERIOD(OUT_PERIOD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mf_clk     (mf_clk),
  .mf_tick    (mf_tick),
  .act_code   (act_code),
  .shift_done (shift_done),
  .gear_req   (gear_req),
  .pend_code  (pend_code),
  .terminal   (terminal)
);

// File: tb/sim_gs_mfclk_div.sv
module sim_gs_mfclk_div;

  localparam int PERIOD = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] freq_sel = 2'd0;
  logic       stop_mode = 1'b0;
  logic       gs_en = 1'b0;
  logic       mf_clk, mf_tick, src_tick, shift_done;
  logic [1:0] act_code;

  int n_tests = 0;
  int n_fail  = 0;
  int done_cnt = 0;
  bit run_mon = 0;
  bit finished = 0;

  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  gs_mfclk_div u0 (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .stop_mode(stop_mode),
    .gs_en(gs_en), .mf_clk(mf_clk), .mf_tick(mf_tick), .src_tick(src_tick),
    .act_code(act_code), .shift_done(shift_done)
  );

  function automatic int ratio_for(input int code);
    case (code)
      0: return 8;
      1: return 6;
      2: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!mf_tick);
    end
  endtask

  // driver: apply a setting, then queue the code expected after settling
  task automatic drive(input logic [1:0] s, input logic st, input logic g,
                       input int exp, input string tag);
    @(negedge clk);
    freq_sel = s; stop_mode = st; gs_en = g;
    wait_ticks(3);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    wait_ticks(2);
  endtask

  // monitor: period, edge count, duty, commit timing, scoreboard compare
  initial begin
    int  cyc = 0, srcn = 0, hin = 0, code_lat = 0, prev_act = 0;
    bit  have_prev = 0, exp_tick = 0;
    forever begin
      @(negedge clk);
      if (run_mon) begin
        cyc++;
        if (shift_done) done_cnt++;
        if (exp_tick) chk(mf_tick == 1'b1, "R5 tick follows code change", int'(mf_tick), 1);
        exp_tick = 0;
        if (int'(act_code) != prev_act) begin
          chk(shift_done == 1'b1, "R6 done with change", int'(shift_done), 1);
          exp_tick = 1;
        end else if (shift_done) begin
          chk(0, "R6 done without change", 1, 0);
        end
        prev_act = int'(act_code);
        if (mf_tick) begin
          if (have_prev) begin
            chk(cyc == PERIOD, "R1 period", cyc, PERIOD);
            chk(srcn == ratio_for(code_lat), "R3 src edges per period", srcn, ratio_for(code_lat));
            chk(hin == PERIOD / 2, "R4 duty", hin, PERIOD / 2);
          end
          chk(mf_clk == 1'b1, "R4 clk rises with tick", int'(mf_clk), 1);
          have_prev = 1;
          code_lat = int'(act_code);
          cyc = 0;
          srcn = int'(src_tick);
          hin = int'(mf_clk);
          if (exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(int'(act_code) == e, t, int'(act_code), e);
          end
        end else begin
          srcn += int'(src_tick);
          hin  += int'(mf_clk);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int d0, old;
    // R2 reset state
    repeat (5) @(negedge clk);
    chk(act_code == 2'd0, "R2 reset code", int'(act_code), 0);
    chk(mf_clk == 1'b0, "R2 reset mf_clk", int'(mf_clk), 0);
    chk(shift_done == 1'b0, "R2 reset done", int'(shift_done), 0);
    rst_n = 1'b1;
    run_mon = 1;
    @(negedge clk);
    chk(mf_tick == 1'b1, "R2 first tick after release", int'(mf_tick), 1);
    chk(act_code == 2'd0, "R2 base after release", int'(act_code), 0);

    // R3 all user settings
    drive(2'd0, 1'b0, 1'b0, 0, "R2 default base");
    drive(2'd1, 1'b0, 1'b0, 1, "R3 24MHz code");
    drive(2'd2, 1'b0, 1'b0, 2, "R3 16MHz code");
    drive(2'd3, 1'b0, 1'b0, 3, "R3 4MHz code");
    drive(2'd0, 1'b0, 1'b0, 0, "R3 back to 32MHz");

    // R7 stop without gear shift is ignored
    d0 = done_cnt;
    drive(2'd0, 1'b1, 1'b0, 0, "R7 stop ignored");
    chk(done_cnt == d0, "R7 no done when ignored", done_cnt - d0, 0);

    // R7 gear shift in and out of stop
    drive(2'd0, 1'b1, 1'b1, 3, "R7 gear to low");
    drive(2'd0, 1'b0, 1'b1, 0, "R7 gear back to base");
    drive(2'd2, 1'b0, 1'b1, 2, "R7 user 16MHz");
    drive(2'd2, 1'b1, 1'b1, 3, "R7 gear low from 16MHz");
    drive(2'd2, 1'b0, 1'b1, 2, "R7 return to user code");
    drive(2'd0, 1'b0, 1'b1, 0, "R8 setup base");

    // R8 same-cycle user change and gear shift
    @(negedge clk);
    freq_sel = 2'd1; stop_mode = 1'b1;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      chk(act_code != 2'd1, "R8 user code never committed", int'(act_code), 3);
    end
    chk(act_code == 2'd3, "R8 gear shift wins", int'(act_code), 3);

    // R5 mid-period request held until boundary
    drive(2'd0, 1'b0, 1'b0, 0, "R5 setup base");
    wait_ticks(1);
    repeat (4) @(negedge clk);
    old = int'(act_code);
    d0 = done_cnt;
    freq_sel = 2'd2;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(int'(act_code) == old, "R5 held mid-period", int'(act_code), old);
    end
    wait_ticks(2);
    chk(act_code == 2'd2, "R5 committed at boundary", int'(act_code), 2);
    chk(done_cnt - d0 == 1, "R6 one done pulse", done_cnt - d0, 1);

    wait_ticks(2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule